// File: doc/BRIEF.md
# Joypad Serial Clock Generator

This block produces the shift clocks for two serial controller ports. On every CPU cycle it is told, for each port, whether the CPU is reading that port's register and whether a DMA fetch is also activating it. From that stream it decides when each controller must see a shift clock. It issues a one-cycle clock pulse per port and keeps a running clock count per port, which a checker or a trace can compare against known console behaviour.

A single mode input selects between two console behaviours:

- **Run mode.** A port is clocked once for each unbroken stretch of consecutive cycles that read it.
- **Every-cycle mode.** A port is clocked on each cycle that reads it.

DMA activity on a port joins the surrounding CPU reads into one stretch. A cycle on which the port is not read ends the stretch. In run mode this decides whether an extra clock is lost or gained around a DMA steal.

Each port has its own two-state machine. The states are `ST_IDLE` (the last cycle did not read the port) and `ST_RUN` (the last cycle read the port). The transitions are:

- **start**: `ST_IDLE` to `ST_RUN` on a reading cycle.
- **hold**: `ST_RUN` to `ST_RUN` on a reading cycle.
- **break**: `ST_RUN` to `ST_IDLE` on a non-reading cycle.
- **rest**: `ST_IDLE` to `ST_IDLE` on a non-reading cycle.

Top module: `jpc_clock_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, every `clk_pulse` bit is 0 and every port count is 0.
- R2: With `mode_every` = 0 (run mode), a port pulses exactly once per unbroken run of reading cycles. The pulse is high in the cycle after the run's first reading cycle, and is low for the cycles that continue the run.
- R3: With `mode_every` = 1 (every-cycle mode), a port's pulse is high in the cycle after each of its reading cycles.
- R4: A cycle reads port p when `cpu_rd[p]`, `dma_rd[p]`, or both are high. A cycle with both high yields one clock, not two.
- R5: A DMA read of a port placed between CPU reads of that same port continues the run. In run mode no extra clock results.
- R6: A cycle on which a port is read by neither source ends that port's run, so the next read starts a new run. A DMA read that activates only the other port does not continue this port's run.
- R7: The two ports are tracked independently. Port 0 uses bit 0 of the strobe vectors and `clk_count[7:0]`; port 1 uses bit 1 and `clk_count[15:8]`.
- R8: A port's count rises by exactly one in every cycle in which its pulse is high and is unchanged otherwise. It wraps modulo 2^CNT_W (256 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_every | input | 1 | 0 = clock once per run, 1 = clock on every reading cycle |
| cpu_rd | input | NUM_PORTS | Per-port CPU read strobe for this cycle |
| dma_rd | input | NUM_PORTS | Per-port DMA activation strobe for this cycle |
| clk_pulse | output | NUM_PORTS | Registered shift clock pulse per port |
| clk_count | output | NUM_PORTS*CNT_W | Packed per-port clock counts, port p at [p*CNT_W +: CNT_W] |

## Verification
Two kinds of event can fall in the same cycle on one port: a CPU read and a DMA activation. The read on the far side of a DMA steal can also coincide with the steal itself. The bench provokes these with cycle patterns taken from real DMA interleavings: a halt cycle, a three-cycle steal, a double steal, and a steal that fetches from the same port or from the other port. It drives each pattern in both modes. The bench judges the result by the count delta on each port after the pattern settles, and by checking the pulse cycle by cycle in directed tests.

// File: rtl/jpc_pkg.sv
package jpc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } port_state_t;

endpackage

// File: rtl/jpc_port_tracker.sv
module jpc_port_tracker
    import jpc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_every,
    input  logic             cpu_rd,
    input  logic             dma_rd,
    output logic             pulse,
    output logic [CNT_W-1:0] count
);

    port_state_t state_q;
    port_state_t state_d;
    logic        active;
    logic        pulse_d;

    // Either source activates the port; both together count as one read.
    assign active = cpu_rd | dma_rd;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = active ? ST_RUN : ST_IDLE;
            ST_RUN:  state_d = active ? ST_RUN : ST_IDLE;
        endcase
    end

    always_comb begin
        pulse_d = 1'b0;
        unique case (state_q)
            ST_IDLE: pulse_d = active;
            ST_RUN:  pulse_d = active & mode_every;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            count <= '0;
        end else begin
            pulse <= pulse_d;
            count <= count + CNT_W'(pulse_d);
        end
    end

    AST_RUN_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && active && !mode_every) |=> !pulse); // R2

    AST_EVERY_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_every && active) |=> pulse); // R3

    AST_PULSE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(active)); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (count == $past(count) + CNT_W'(1))); // R8

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |-> $stable(count)); // R8

endmodule

// File: rtl/jpc_clock_gen.sv
module jpc_clock_gen
    import jpc_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int CNT_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mode_every,
    input  logic [NUM_PORTS-1:0]       cpu_rd,
    input  logic [NUM_PORTS-1:0]       dma_rd,
    output logic [NUM_PORTS-1:0]       clk_pulse,
    output logic [NUM_PORTS*CNT_W-1:0] clk_count
);

    localparam int CNT_TOTAL = NUM_PORTS * CNT_W;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        jpc_port_tracker #(
            .CNT_W (CNT_W)
        ) i_tracker (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode_every (mode_every),
            .cpu_rd     (cpu_rd[p]),
            .dma_rd     (dma_rd[p]),
            .pulse      (clk_pulse[p]),
            .count      (clk_count[p*CNT_W +: CNT_W])
        );
    end

    AST_IDLE_PORTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rd | dma_rd) == '0) |=> (clk_pulse == '0)); // R6

    AST_COUNT_FIELD_W: assert property (@(posedge clk)
        !rst_n |=> (clk_count == CNT_TOTAL'(0))); // R1

endmodule

// File: tb/test_jpc_clock_gen.sv
module test_jpc_clock_gen;

    localparam int NP = 2;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_every = 1'b0;
    logic [NP-1:0] cpu_rd = '0;
    logic [NP-1:0] dma_rd = '0;
    logic [NP-1:0] clk_pulse;
    logic [NP*CW-1:0] clk_count;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    jpc_clock_gen #(.NUM_PORTS(NP), .CNT_W(CW)) i_jpc_clock_gen (
        .clk(clk), .rst_n(rst_n), .mode_every(mode_every),
        .cpu_rd(cpu_rd), .dma_rd(dma_rd),
        .clk_pulse(clk_pulse), .clk_count(clk_count)
    );

    // bit i of each pattern is cycle i
    typedef struct packed {
        logic [3:0] req;
        logic       mode;
        logic [7:0] c0, d0, c1, d1;
        logic [3:0] e0, e1;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 1'b0, 8'h00, 8'h00, 8'h03, 8'h00, 4'd0, 4'd1}, // R2 halt-split reads
        '{4'd3, 1'b1, 8'h00, 8'h00, 8'h03, 8'h00, 4'd0, 4'd2}, // R3 halt-split reads
        '{4'd6, 1'b0, 8'h00, 8'h00, 8'h0B, 8'h00, 4'd0, 4'd2}, // R6 three-cycle steal
        '{4'd3, 1'b1, 8'h00, 8'h00, 8'h0B, 8'h00, 4'd0, 4'd3}, // R3 three-cycle steal
        '{4'd6, 1'b0, 8'h00, 8'h00, 8'hBB, 8'h00, 4'd0, 4'd3}, // R6 double steal
        '{4'd3, 1'b1, 8'h00, 8'h00, 8'hBB, 8'h00, 4'd0, 4'd6}, // R3 double steal
        '{4'd5, 1'b0, 8'h00, 8'h00, 8'h0B, 8'h04, 4'd0, 4'd1}, // R5 same-port fetch
        '{4'd5, 1'b1, 8'h00, 8'h00, 8'h0B, 8'h04, 4'd0, 4'd4}, // R5 same-port fetch
        '{4'd5, 1'b0, 8'h00, 8'h00, 8'h17, 8'h08, 4'd0, 4'd1}, // R5 late same-port fetch
        '{4'd5, 1'b1, 8'h00, 8'h00, 8'h17, 8'h08, 4'd0, 4'd5}, // R5 late same-port fetch
        '{4'd6, 1'b0, 8'h00, 8'h04, 8'h0B, 8'h00, 4'd1, 4'd2}, // R6 other-port fetch
        '{4'd6, 1'b1, 8'h00, 8'h04, 8'h0B, 8'h00, 4'd1, 4'd3}, // R6 other-port fetch
        '{4'd4, 1'b0, 8'h01, 8'h01, 8'h00, 8'h00, 4'd1, 4'd0}, // R4 both sources
        '{4'd4, 1'b1, 8'h01, 8'h01, 8'h00, 8'h00, 4'd1, 4'd0}, // R4 both sources
        '{4'd7, 1'b0, 8'hF0, 8'h00, 8'h55, 8'h00, 4'd1, 4'd4}, // R7 independent ports
        '{4'd7, 1'b1, 8'hF0, 8'h00, 8'h55, 8'h00, 4'd4, 4'd4}  // R7 independent ports
    };

    function automatic logic [CW-1:0] cnt(input int p);
        return clk_count[p*CW +: CW];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cpu_rd = '0;
            dma_rd = '0;
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [CW-1:0] s0, s1, d0v, d1v, base;
        // R1 reset state
        cpu_rd = '1;
        dma_rd = '1;
        mode_every = 1'b1;
        repeat (3) @(negedge clk);
        check(clk_pulse == '0, "R1 pulse in reset", int'(clk_pulse), 0);
        check(clk_count == '0, "R1 count in reset", int'(clk_count), 0);
        cpu_rd = '0;
        dma_rd = '0;
        rst_n = 1'b1;
        @(negedge clk);
        check(clk_pulse == '0, "R1 pulse after reset", int'(clk_pulse), 0);
        check(clk_count == '0, "R1 count after reset", int'(clk_count), 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            s0 = cnt(0);
            s1 = cnt(1);
            mode_every = VECS[v].mode;
            for (int c = 0; c < 8; c++) begin
                cpu_rd = {VECS[v].c1[c], VECS[v].c0[c]};
                dma_rd = {VECS[v].d1[c], VECS[v].d0[c]};
                @(negedge clk);
            end
            cpu_rd = '0;
            dma_rd = '0;
            idle_cycles(2);
            d0v = cnt(0) - s0;
            d1v = cnt(1) - s1;
            checks++;
            if (d0v != CW'(VECS[v].e0) || d1v != CW'(VECS[v].e1)) begin
                errors++;
                $display("FAIL R%0d vector %0d: actual %0d/%0d expected %0d/%0d",
                         VECS[v].req, v, d0v, d1v, VECS[v].e0, VECS[v].e1);
            end
        end

        // R2 pulse timing in run mode
        mode_every = 1'b0;
        idle_cycles(2);
        cpu_rd = 2'b01;
        @(negedge clk);
        check(clk_pulse == 2'b01, "R2 first read pulses", int'(clk_pulse), 1);
        @(negedge clk);
        check(clk_pulse == 2'b00, "R2 continued run quiet", int'(clk_pulse), 0);
        dma_rd = 2'b01;
        cpu_rd = 2'b00;
        @(negedge clk);
        check(clk_pulse == 2'b00, "R5 dma keeps run", int'(clk_pulse), 0);
        dma_rd = 2'b00;
        @(negedge clk);
        cpu_rd = 2'b10;
        @(negedge clk);
        check(clk_pulse == 2'b10, "R6 new run after gap", int'(clk_pulse), 2);

        // R3 pulse timing in every-cycle mode
        mode_every = 1'b1;
        cpu_rd = 2'b11;
        @(negedge clk);
        check(clk_pulse == 2'b11, "R3 every cycle pulse", int'(clk_pulse), 3);
        @(negedge clk);
        check(clk_pulse == 2'b11, "R3 every cycle repeat", int'(clk_pulse), 3);
        cpu_rd = 2'b00;
        @(negedge clk);
        check(clk_pulse == 2'b00, "R3 no read no pulse", int'(clk_pulse), 0);

        // R8 wrap of port 0 counter
        base = cnt(0);
        s1 = cnt(1);
        cpu_rd = 2'b01;
        for (int k = 0; k < 255; k++) @(negedge clk);
        check(cnt(0) == CW'(base - 1), "R8 count before wrap", int'(cnt(0)), int'(CW'(base - 1)));
        @(negedge clk);
        check(cnt(0) == base, "R8 count wraps", int'(cnt(0)), int'(base));
        check(cnt(1) == s1, "R7 other port unchanged", int'(cnt(1)), int'(s1));
        cpu_rd = 2'b00;
        idle_cycles(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule